// File: doc/BRIEF.md
# Floating-Point Result Rounder

This block turns an unrounded floating-point intermediate into a packed binary floating-point word. The format has `EXP_W` exponent bits and `SIG_W` significand bits, of which `SIG_W-1` are stored because the leading one of a normal value is implicit. The intermediate consists of a sign, a biased exponent one bit wider than the field, a `SIG_W`-bit significand, a guard bit for the half-unit position, and a sticky bit that is the OR of everything below the guard. Two flags describe zero results: one marks an exact zero, and the other marks a zero produced by cancelling opposite-signed operands. A 3-bit mode code travels with each item.

The value is `sig * 2^(max(exp,1) - bias - (SIG_W-1))`. The producer supplies normalised operands: when `exp >= 1` the significand MSB is 1, and when `exp == 0` (subnormal scale) it is 0. Input and output are valid/ready streams with one register stage. An item is taken when `in_valid && in_ready`. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, `out_data` is held unchanged and no new item is taken. A taken item appears on `out_data` in the next cycle.

Top module: `fpr_round_unit`

## Requirements
- R1: The output is `{sign, exp[EXP_W-1:0], frac[SIG_W-2:0]}`. When guard and sticky are both 0, the input is packed unchanged in every mode.
- R2: Mode code 0 (nearest, ties to even) rounds up when guard is 1 and sticky is 1. On a tie (guard 1, sticky 0) it rounds up only when significand bit 0 is 1.
- R3: Mode code 1 (nearest, ties away) rounds the magnitude up whenever guard is 1.
- R4: Mode code 2 (toward +inf) rounds an inexact positive value up and truncates a negative one. Mode code 3 (toward -inf) does the reverse.
- R5: Mode code 4 (toward zero) always truncates and never produces infinity.
- R6: When the increment carries out of the significand, the exponent rises by one and the fraction becomes 0. A subnormal that rounds up to the hidden-bit position leaves with exponent field 1.
- R7: A rounded exponent of all ones or more is an overflow. Mode 4, mode 2 with a negative sign, and mode 3 with a positive sign give the largest finite value: exponent all ones minus one, fraction all ones. Every other mode gives infinity: exponent all ones, fraction 0. The sign is kept in both cases.
- R8: An exact-zero item yields exponent 0 and fraction 0. Its sign is the input sign, unless the cancel flag is set, in which case the sign is 1 only in mode 3.
- R9: Mode codes 5, 6 and 7 behave exactly as mode code 0.
- R10: `in_ready` equals `!out_valid || out_ready`. A stalled output keeps `out_data` stable until it is accepted.
- R11: During and right after reset, `out_valid` is 0 and `in_ready` is 1.
- R12: The output never carries a NaN pattern (exponent all ones with a non-zero fraction).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input item present |
| in_ready | output | 1 | Input item can be taken |
| in_sign | input | 1 | Sign of the intermediate |
| in_exp | input | EXP_W+1 | Biased exponent, may exceed the field range |
| in_sig | input | SIG_W | Significand including the leading bit |
| in_guard | input | 1 | Half-unit bit below the significand |
| in_sticky | input | 1 | OR of all lower bits |
| in_zero | input | 1 | Exact-zero result |
| in_cancel | input | 1 | Zero came from opposite-signed cancellation |
| in_mode | input | 3 | Rounding mode code |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer accepts the result |
| out_data | output | EXP_W+SIG_W | Packed rounded result |

## Verification
A wrong round-up decision shows as an encoding exactly one unit in the last place away from the expected one. It appears on the next accepted result after the offending item, so a random mix of modes, guard and sticky bits, and lsb values exposes it within a few items. A faulty carry or overflow path produces a wrong exponent field or a NaN-shaped word on that same result. Handshake faults show up at once, either as `in_ready` disagreeing with the output state or as `out_data` moving while the output is stalled.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'd0,
    RM_NEAR_AWAY = 3'd1,
    RM_UP        = 3'd2,
    RM_DOWN      = 3'd3,
    RM_ZERO      = 3'd4
  } rmode_e;

  // Codes beyond the five defined modes fall back to nearest-even (R9)
  function automatic rmode_e clean_mode(input logic [2:0] code);
    rmode_e m;
    case (code)
      3'd1: m = RM_NEAR_AWAY;
      3'd2: m = RM_UP;
      3'd3: m = RM_DOWN;
      3'd4: m = RM_ZERO;
      default: m = RM_NEAR_EVEN;
    endcase
    return m;
  endfunction
endpackage

// File: rtl/fpr_decide.sv
module fpr_decide
  import fpr_pkg::*;
(
  input  rmode_e mode,
  input  logic   sign,
  input  logic   lsb,
  input  logic   guard,
  input  logic   sticky,
  output logic   up
);
  logic inexact;
  assign inexact = guard | sticky;

  always_comb begin
    case (mode)
      RM_NEAR_AWAY: up = guard;
      RM_UP:        up = inexact & ~sign;
      RM_DOWN:      up = inexact & sign;
      RM_ZERO:      up = 1'b0;
      default:      up = guard & (sticky | lsb);
    endcase
  end
endmodule

// File: rtl/fpr_incr.sv
module fpr_incr #(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24
) (
  input  logic [EXP_W:0]   exp_in,
  input  logic [SIG_W-1:0] sig_in,
  input  logic             up,
  output logic [EXP_W+1:0] exp_out,
  output logic [SIG_W-2:0] frac_out
);
  logic [SIG_W:0] sum;
  logic           carry;

  assign sum   = {1'b0, sig_in} + {{SIG_W{1'b0}}, up};
  assign carry = sum[SIG_W];

  always_comb begin
    if (carry) begin
      exp_out  = {1'b0, exp_in} + {{(EXP_W+1){1'b0}}, 1'b1};
      frac_out = sum[SIG_W-1:1];
    end else begin
      frac_out = sum[SIG_W-2:0];
      if (exp_in == '0 && sum[SIG_W-1])
        exp_out = {{(EXP_W+1){1'b0}}, 1'b1};
      else
        exp_out = {1'b0, exp_in};
    end
  end
endmodule

// File: rtl/fpr_pack.sv
module fpr_pack
  import fpr_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24,
  localparam int OW   = EXP_W + SIG_W
) (
  input  rmode_e           mode,
  input  logic             sign,
  input  logic             zero,
  input  logic             cancel,
  input  logic [EXP_W+1:0] exp_r,
  input  logic [SIG_W-2:0] frac_r,
  output logic [OW-1:0]    word
);
  localparam logic [EXP_W+1:0] TOP_E = (EXP_W+2)'((1 << EXP_W) - 1);
  localparam logic [EXP_W-1:0] ONES_E = '1;

  logic ovf, hold_max, zsign;

  assign ovf      = exp_r >= TOP_E;
  assign hold_max = (mode == RM_ZERO) || (mode == RM_UP && sign) ||
                    (mode == RM_DOWN && !sign);
  assign zsign    = cancel ? (mode == RM_DOWN) : sign;

  always_comb begin
    if (zero)
      word = {zsign, {(OW-1){1'b0}}};
    else if (ovf && hold_max)
      word = {sign, ONES_E - 1'b1, {(SIG_W-1){1'b1}}};
    else if (ovf)
      word = {sign, ONES_E, {(SIG_W-1){1'b0}}};
    else
      word = {sign, exp_r[EXP_W-1:0], frac_r};
  end
endmodule

// File: rtl/fpr_round_unit.sv
module fpr_round_unit
  import fpr_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24,
  localparam int OW   = EXP_W + SIG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic             in_sign,
  input  logic [EXP_W:0]   in_exp,
  input  logic [SIG_W-1:0] in_sig,
  input  logic             in_guard,
  input  logic             in_sticky,
  input  logic             in_zero,
  input  logic             in_cancel,
  input  logic [2:0]       in_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [OW-1:0]    out_data
);
  rmode_e           mode;
  logic             up;
  logic [EXP_W+1:0] exp_r;
  logic [SIG_W-2:0] frac_r;
  logic [OW-1:0]    word;
  logic             take;

  assign mode = clean_mode(in_mode);

  fpr_decide u_decide (
    .mode(mode), .sign(in_sign), .lsb(in_sig[0]),
    .guard(in_guard), .sticky(in_sticky), .up(up)
  );

  fpr_incr #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_incr (
    .exp_in(in_exp), .sig_in(in_sig), .up(up),
    .exp_out(exp_r), .frac_out(frac_r)
  );

  fpr_pack #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_pack (
    .mode(mode), .sign(in_sign), .zero(in_zero), .cancel(in_cancel),
    .exp_r(exp_r), .frac_r(frac_r), .word(word)
  );

  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_data  <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/fpr_round_chk.sv
module fpr_round_chk #(
  parameter int EXP_W = 8,
  parameter int SIG_W = 24,
  localparam int OW   = EXP_W + SIG_W
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_zero,
  input logic [2:0]    in_mode,
  input logic          out_valid,
  input logic          out_ready,
  input logic [OW-1:0] out_data
);
  logic [EXP_W-1:0] oexp;
  logic [SIG_W-2:0] ofrac;
  assign oexp  = out_data[OW-2 -: EXP_W];
  assign ofrac = out_data[SIG_W-2:0];

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R10
  stall_block_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);

  // R12
  no_nan_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !(oexp == '1 && ofrac != '0));

  // R5
  zero_mode_finite_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_mode == 3'd4 && !in_zero) |=> (oexp != '1));

  // R8
  exact_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && in_zero) |=> (out_data[OW-2:0] == '0));
endmodule

bind fpr_round_unit fpr_round_chk #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .in_zero(in_zero), .in_mode(in_mode), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data)
);

// File: tb/sim_fpr_round_unit.sv
module sim_fpr_round_unit;
  localparam int EW = 5;
  localparam int SW = 6;
  localparam int OW = EW + SW;
  localparam int MAXE = (1 << EW) - 1;
  localparam int TOTAL = 3000;
  localparam int ND = 16;

  logic clk = 1'b0;
  logic rst;
  logic in_valid, in_ready, in_sign, in_guard, in_sticky, in_zero, in_cancel;
  logic [EW:0] in_exp;
  logic [SW-1:0] in_sig;
  logic [2:0] in_mode;
  logic out_valid, out_ready;
  logic [OW-1:0] out_data;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fpr_round_unit #(.EXP_W(EW), .SIG_W(SW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
    .in_guard(in_guard), .in_sticky(in_sticky), .in_zero(in_zero),
    .in_cancel(in_cancel), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  function automatic bit round_up(input int m, input bit s, input bit lsb, input bit g, input bit st);
    case (m)
      1: return g;
      2: return (g | st) & ~s;
      3: return (g | st) & s;
      4: return 1'b0;
      default: return g & (st | lsb);
    endcase
  endfunction

  // Encoded magnitude is monotonic: rounding up is +1 on {exp,frac}.
  function automatic logic [OW-1:0] ref_word(input bit s, input int e, input int sg,
      input bit g, input bit st, input bit z, input bit c, input int code);
    int m, enc, lim;
    bit sat;
    m = (code > 4) ? 0 : code;
    if (z) return {(c ? (m == 3) : s), {(OW-1){1'b0}}};
    if (e == 0) enc = sg;
    else enc = e * (1 << (SW-1)) + (sg % (1 << (SW-1)));
    enc = enc + int'(round_up(m, s, sg[0], g, st));
    lim = MAXE * (1 << (SW-1));
    if (enc >= lim) begin
      sat = (m == 4) || (m == 2 && s) || (m == 3 && !s);
      enc = sat ? lim - 1 : lim;
    end
    return {s, enc[OW-2:0]};
  endfunction

  function automatic string tag_of(input bit s, input int e, input int sg,
      input bit g, input bit st, input bit z, input int code);
    int enc;
    if (z) return "R8";
    if (code > 4) return "R9";
    enc = (e == 0) ? sg : e * (1 << (SW-1)) + (sg % (1 << (SW-1)));
    if (enc + int'(round_up(code, s, sg[0], g, st)) >= MAXE * (1 << (SW-1))) return "R7";
    if (((enc + 1) % (1 << (SW-1))) == 0 && round_up(code, s, sg[0], g, st)) return "R6";
    if (!g && !st) return "R1";
    case (code)
      0: return "R2";
      1: return "R3";
      4: return "R5";
      default: return "R4";
    endcase
  endfunction

  task automatic load(input bit s, input int e, input int sg, input bit g,
      input bit st, input bit z, input bit c, input int m);
    in_sign = s; in_exp = e[EW:0]; in_sig = sg[SW-1:0]; in_guard = g;
    in_sticky = st; in_zero = z; in_cancel = c; in_mode = m[2:0];
  endtask

  task automatic load_directed(input int i);
    case (i)
      0:  load(0, 10, 'b100001, 1, 0, 0, 0, 0); // R2 tie, odd lsb -> up
      1:  load(0, 10, 'b100000, 1, 0, 0, 0, 0); // R2 tie, even lsb -> stay
      2:  load(1, 10, 'b100000, 1, 0, 0, 0, 1); // R3 tie away
      3:  load(1, 12, 'b101010, 0, 1, 0, 0, 2); // R4 negative toward +inf truncates
      4:  load(0, 12, 'b101010, 0, 1, 0, 0, 2); // R4 positive toward +inf up
      5:  load(1, 12, 'b101010, 0, 1, 0, 0, 3); // R4 negative toward -inf up
      6:  load(0, 10, 'b111111, 1, 1, 0, 0, 4); // R5 truncation
      7:  load(0, 10, 'b111111, 1, 1, 0, 0, 0); // R6 carry
      8:  load(0, 0,  'b011111, 1, 1, 0, 0, 0); // R6 subnormal to exp 1
      9:  load(0, 30, 'b111111, 1, 0, 0, 0, 0); // R7 infinity
      10: load(0, 30, 'b111111, 1, 1, 0, 0, 4); // R7 max finite
      11: load(1, 30, 'b111111, 1, 1, 0, 0, 3); // R7 -inf
      12: load(0, 30, 'b111111, 1, 1, 0, 0, 3); // R7 +max finite
      13: load(0, 0, 0, 0, 0, 1, 1, 3);         // R8 cancel toward -inf
      14: load(1, 0, 0, 0, 0, 1, 1, 0);         // R8 cancel nearest -> +0
      default: load(0, 10, 'b100001, 1, 0, 0, 0, 6); // R9 code 6 as ties-even
    endcase
  endtask

  task automatic load_random();
    int e, sg;
    bit z;
    e = $urandom % (MAXE + 3);
    sg = $urandom % (1 << SW);
    if (e == 0) sg = sg % (1 << (SW-1));
    else sg = sg | (1 << (SW-1));
    z = ($urandom % 16) == 0;
    load($urandom % 2, e, sg, $urandom % 2, $urandom % 2, z, z & ($urandom % 2), $urandom % 8);
  endtask

  logic [OW-1:0] q[$];
  string tq[$];
  logic [OW-1:0] held;
  bit stalled = 0;

  initial begin
    int sent, idx;
    bit took;
    void'($urandom(32'd4242));
    rst = 1; in_valid = 0; out_ready = 0;
    load(0, 0, 0, 0, 0, 0, 0, 0);
    sent = 0; idx = 0; took = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R11", out_valid, 0);
    check(in_ready == 1'b1, "R11", in_ready, 1);
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    check(out_valid == 1'b0, "R11", out_valid, 0);
    while (sent < TOTAL || q.size() != 0 || out_valid) begin
      @(posedge clk); #1;
      if (!in_valid || took) begin
        if (sent + (in_valid ? 0 : 0) < TOTAL && (idx < ND || ($urandom % 4) != 0)) begin
          if (idx < ND) load_directed(idx); else load_random();
          idx++;
          in_valid = 1;
        end else in_valid = 0;
      end
      if (sent >= TOTAL) in_valid = 0;
      out_ready = (($urandom % 10) < 7) || (sent >= TOTAL);
      @(negedge clk);
      // R10 ready rule and stall stability
      check(in_ready == (!out_valid || out_ready), "R10", in_ready, !out_valid || out_ready);
      if (stalled && out_valid)
        check(out_data == held, "R10", out_data, held);
      stalled = out_valid && !out_ready;
      held = out_data;
      if (out_valid && out_ready) begin
        logic [OW-1:0] e_w;
        string t;
        if (q.size() == 0) check(1'b0, "R10", 1, 0);
        else begin
          e_w = q.pop_front();
          t = tq.pop_front();
          check(out_data == e_w, t, out_data, e_w);
          // R12 no NaN shape
          check(!(out_data[OW-2 -: EW] == '1 && out_data[SW-2:0] != '0), "R12", out_data, e_w);
        end
      end
      took = in_valid && in_ready;
      if (took) begin
        q.push_back(ref_word(in_sign, int'(in_exp), int'(in_sig), in_guard, in_sticky,
                             in_zero, in_cancel, int'(in_mode)));
        tq.push_back(tag_of(in_sign, int'(in_exp), int'(in_sig), in_guard, in_sticky,
                            in_zero, int'(in_mode)));
        sent++;
      end
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule